// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block sits between two parallel buses, called A and B, and moves data across in either direction. Each direction has a storage bank of its own and three active-LOW controls of its own: a direction enable, a latch enable and an output enable. Data can be taken from one bus, kept, and later driven onto the other bus without inversion. The two directions are independent, so one bank can capture while the other drives previously stored data.

Inside a chip there are no real three-state nets. Each destination bus is therefore a drive vector plus a single drive-enable flag, and a cleared flag stands for high impedance. Each storage bank is level-transparent. While it is open, the source reaches the destination in the same evaluation, with no clock edge in between. The value it keeps is registered on the clock, so the controls are expected to be synchronous to `clk`. A synchronous active-LOW reset clears both banks.

Top module: `dlx_xcvr`

## Requirements
- R1: When `rst_n` is LOW at a rising edge of `clk`, both banks are cleared to zero. After reset, enabling a bank's output without opening it drives all zeros with the flag set.
- R2: When `ab_en_n` and `ab_le_n` are both LOW, the A-to-B bank is open. Its contents equal `a_in` (bit i to bit i), and with `ab_oe_n` LOW, `b_out` follows `a_in` with no clock edge.
- R3: When the bank closes because `ab_le_n` or `ab_en_n` goes HIGH, it keeps the `a_in` value present at the last rising clock edge while it was open. Later changes on `a_in` do not reach it.
- R4: While `ab_en_n` is HIGH, the A-to-B bank keeps its contents whatever `ab_le_n` and `a_in` do.
- R5: `b_oe` is 1 exactly when `ab_en_n` and `ab_oe_n` are both LOW. In that case `b_out` equals the A-to-B bank contents. When `b_oe` is 0, `b_out` is all zeros.
- R6: With `ab_en_n` HIGH, `b_oe` is 0 even when `ab_oe_n` is LOW.
- R7: The B-to-A direction obeys R2 to R6 with `b_in`, `ba_en_n`, `ba_le_n`, `ba_oe_n`, `a_out` and `a_oe` in place of their A-to-B counterparts.
- R8: The controls of one direction never change the bank contents, drive value or flag of the other direction. One bank can be open while the other drives held data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that registers the held bank contents |
| rst_n | input | 1 | Synchronous active-LOW reset |
| a_in | input | WIDTH | Value present on bus A |
| a_out | output | WIDTH | Drive value towards bus A (zero when not driving) |
| a_oe | output | 1 | Bus A drive enable; 0 means high impedance |
| b_in | input | WIDTH | Value present on bus B |
| b_out | output | WIDTH | Drive value towards bus B (zero when not driving) |
| b_oe | output | 1 | Bus B drive enable; 0 means high impedance |
| ab_en_n | input | 1 | A-to-B direction enable, active LOW |
| ab_le_n | input | 1 | A-to-B latch enable, active LOW |
| ab_oe_n | input | 1 | A-to-B output enable, active LOW |
| ba_en_n | input | 1 | B-to-A direction enable, active LOW |
| ba_le_n | input | 1 | B-to-A latch enable, active LOW |
| ba_oe_n | input | 1 | B-to-A output enable, active LOW |

## Verification
The bench builds the block with `WIDTH = 4`. At that width it can sweep all eight control settings of each direction against all sixteen values on each bus, one vector per clock. The sweep crosses every A-to-B setting with every B-to-A setting, so every open, closed, driving and idle combination meets every data pattern. Each bank is also opened and closed many times with known data, which makes every hold and capture case reachable. Directed steps on top of the sweep cover the cleared state after reset and a phase where one bank captures while the other drives held data.

// File: rtl/dlx_pkg.sv
// Shared types for the dual-direction latched transceiver.
// Assumes exactly two directions, indexed by the constants below.
package dlx_pkg;
    localparam int NUM_DIR = 2;
    localparam int DIR_AB  = 0;
    localparam int DIR_BA  = 1;

    // Active-LOW control triple of one direction
    typedef struct packed {
        logic en_n;
        logic le_n;
        logic oe_n;
    } dir_ctrl_t;
endpackage

// File: rtl/dlx_latch_bank.sv
// One storage bank: transparent while enabled, otherwise shows the registered
// copy. Assumes the controls are synchronous to clk, so the kept value is the
// source sampled at the last edge while the bank was open.
module dlx_latch_bank
    import dlx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dir_ctrl_t        ctrl,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] q
);
    logic             open;
    logic [WIDTH-1:0] held;

    // Bank opens only when direction and latch enables are both LOW
    assign open = !ctrl.en_n && !ctrl.le_n;

    // Visible contents: source while open, kept copy while closed
    always_comb begin
        q = open ? src : held;
    end

    // Register the visible contents each edge; reset clears the bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else begin
            held <= q;
        end
    end
endmodule

// File: rtl/dlx_out_gate.sv
// Output gating of one direction: drives the bank contents when direction and
// output enables are both LOW, otherwise flags high impedance with zero data.
module dlx_out_gate
    import dlx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  dir_ctrl_t        ctrl,
    input  logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] drv,
    output logic             oe
);
    // Decide drive enable and drive value for the destination bus
    always_comb begin
        oe  = !ctrl.en_n && !ctrl.oe_n;
        drv = oe ? q : '0;
    end
endmodule

// File: rtl/dlx_xcvr.sv
// Top of the dual-direction latched transceiver. Builds one bank and one
// output gate per direction; the two directions share nothing but clk/rst_n.
module dlx_xcvr
    import dlx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             ab_en_n,
    input  logic             ab_le_n,
    input  logic             ab_oe_n,
    input  logic             ba_en_n,
    input  logic             ba_le_n,
    input  logic             ba_oe_n
);
    dir_ctrl_t        ctrl [NUM_DIR];
    logic [WIDTH-1:0] src  [NUM_DIR];
    logic [WIDTH-1:0] q    [NUM_DIR];
    logic [WIDTH-1:0] drv  [NUM_DIR];
    logic             oe   [NUM_DIR];
    logic [WIDTH-1:0] q_ab;
    logic [WIDTH-1:0] q_ba;

    // Route port controls and sources into per-direction arrays
    always_comb begin
        ctrl[DIR_AB] = '{en_n: ab_en_n, le_n: ab_le_n, oe_n: ab_oe_n};
        ctrl[DIR_BA] = '{en_n: ba_en_n, le_n: ba_le_n, oe_n: ba_oe_n};
        src[DIR_AB]  = a_in;
        src[DIR_BA]  = b_in;
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        dlx_latch_bank #(.WIDTH(WIDTH)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .ctrl  (ctrl[d]),
            .src   (src[d]),
            .q     (q[d])
        );
        dlx_out_gate #(.WIDTH(WIDTH)) u_gate (
            .ctrl (ctrl[d]),
            .q    (q[d]),
            .drv  (drv[d]),
            .oe   (oe[d])
        );
    end

    // Map per-direction results back to the destination bus ports
    always_comb begin
        b_out = drv[DIR_AB];
        b_oe  = oe[DIR_AB];
        a_out = drv[DIR_BA];
        a_oe  = oe[DIR_BA];
        q_ab  = q[DIR_AB];
        q_ba  = q[DIR_BA];
    end
endmodule

// File: rtl/dlx_xcvr_chk.sv
// Property checker for dlx_xcvr, attached by bind. Watches the ports and the
// bank contents of each direction.
module dlx_xcvr_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             ab_en_n,
    input logic             ab_le_n,
    input logic             ab_oe_n,
    input logic             ba_en_n,
    input logic             ba_le_n,
    input logic             ba_oe_n,
    input logic [WIDTH-1:0] q_ab,
    input logic [WIDTH-1:0] q_ba
);
    AST_AB_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_en_n && !ab_le_n) |-> (q_ab == a_in)); // R2
    AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ab_en_n && !$past(ab_en_n) && $rose(ab_le_n)) |-> (q_ab == $past(a_in))); // R3
    AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ab_en_n && $past(ab_en_n)) |-> $stable(q_ab)); // R4
    AST_AB_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe |-> (b_out == q_ab && !ab_oe_n)); // R5
    AST_AB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !b_oe |-> (b_out == '0)); // R5
    AST_AB_DIR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ab_en_n |-> !b_oe); // R6

    AST_BA_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_en_n && !ba_le_n) |-> (q_ba == b_in)); // R7
    AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ba_en_n && !$past(ba_en_n) && $rose(ba_le_n)) |-> (q_ba == $past(b_in))); // R7
    AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ba_en_n && $past(ba_en_n)) |-> $stable(q_ba)); // R7
    AST_BA_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe |-> (a_out == q_ba && !ba_oe_n)); // R7
    AST_BA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !a_oe |-> (a_out == '0)); // R7
    AST_BA_DIR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ba_en_n |-> !a_oe); // R7
endmodule

bind dlx_xcvr dlx_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dlx_xcvr_bench.sv
// Sweep bench for dlx_xcvr at WIDTH=4 with an arithmetic reference model.
module dlx_xcvr_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe;
    logic         ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n;

    int unsigned  n_vec  = 0;
    int unsigned  n_fail = 0;
    logic [W-1:0] m_ab, m_ba;   // reference copies of the kept bank values
    bit           done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    dlx_xcvr #(.WIDTH(W)) u_dlx_xcvr (.*);

    task automatic chk1(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare both destinations with the reference, using current inputs
    task automatic check_all();
        logic [W-1:0] cab, cba;
        logic         eab, eba;
        cab = (!ab_en_n && !ab_le_n) ? a_in : m_ab;
        cba = (!ba_en_n && !ba_le_n) ? b_in : m_ba;
        eab = !ab_en_n && !ab_oe_n;
        eba = !ba_en_n && !ba_oe_n;
        chk1(ab_en_n ? "R6" : "R5", "b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, eab});
        chk1(!eab ? "R5" : (!ab_le_n && !ab_en_n) ? "R2" : "R3/R4", "b_out",
             b_out, eab ? cab : '0);
        chk1("R7", "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, eba});
        chk1("R7", "a_out", a_out, eba ? cba : '0);
    endtask

    // Apply one vector after a falling edge, check, then advance the model
    task automatic apply(logic [2:0] cab, logic [2:0] cba, logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        {ab_en_n, ab_le_n, ab_oe_n} = cab;
        {ba_en_n, ba_le_n, ba_oe_n} = cba;
        a_in = a;
        b_in = b;
        #1;
        check_all();
        @(posedge clk);
        if (!ab_en_n && !ab_le_n) m_ab = a_in;
        if (!ba_en_n && !ba_le_n) m_ba = b_in;
    endtask

    initial begin
        rst_n = 1'b0;
        {ab_en_n, ab_le_n, ab_oe_n} = 3'b111;
        {ba_en_n, ba_le_n, ba_oe_n} = 3'b111;
        a_in = '0;
        b_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_ab = '0;
        m_ba = '0;

        // R1: reset cleared both banks; enable outputs with banks closed
        @(negedge clk);
        ab_en_n = 1'b0; ab_le_n = 1'b1; ab_oe_n = 1'b0;
        ba_en_n = 1'b0; ba_le_n = 1'b1; ba_oe_n = 1'b0;
        a_in = '1; b_in = '1;
        #1;
        chk1("R1", "b_out after reset", b_out, '0);
        chk1("R1", "b_oe after reset", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, 1'b1});
        chk1("R1", "a_out after reset", a_out, '0);
        chk1("R1", "a_oe after reset", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, 1'b1});

        // R2: same-evaluation transparency with no clock edge in between
        @(negedge clk);
        ab_le_n = 1'b0;
        a_in = 4'h6;
        #1;
        chk1("R2", "b_out transparent", b_out, 4'h6);
        a_in = 4'h9;
        #1;
        chk1("R2", "b_out follows without edge", b_out, 4'h9);
        @(posedge clk);
        m_ab = 4'h9;

        // R8: A-to-B captures while B-to-A drives its held zero
        apply(3'b001, 3'b010, 4'hC, 4'h5);  // AB open no drive, BA closed driving
        chk1("R8", "a_out held during AB capture", a_out, '0);
        apply(3'b011, 3'b010, 4'h3, 4'hA);  // AB closed, BA still held
        apply(3'b010, 3'b010, 4'h0, 4'hF);  // both drive held data
        chk1("R8", "b_out keeps AB capture", b_out, 4'hC);
        chk1("R8", "a_out untouched by AB", a_out, '0);
        // R3: enable release captures the last sampled value
        apply(3'b000, 3'b110, 4'h7, 4'h1);
        apply(3'b100, 3'b110, 4'h2, 4'h1);
        apply(3'b010, 3'b110, 4'hE, 4'h1);
        chk1("R3", "capture on enable release", b_out, 4'h7);

        // Full cross sweep of controls and data (R2-R8)
        for (int ca = 0; ca < 8; ca++) begin
            for (int cb = 0; cb < 8; cb++) begin
                for (int av = 0; av < (1 << W); av++) begin
                    for (int bv = 0; bv < (1 << W); bv++) begin
                        apply(ca[2:0], cb[2:0], av[W-1:0], bv[W-1:0]);
                    end
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (40000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule